// File: doc/BRIEF.md
# Clock-Synchronous Serial Slave

This block is the slave end of a clock-synchronous serial link. An external master supplies the serial clock. The block brings that clock into the system clock domain through two flip-flops and detects its edges there. On the drive edge it shifts a queued word out, least significant bit first. On the sample edge it collects incoming bits into a receive word of 5 to 9 bits.

Software sees one transmit holding register with an empty flag and one receive register with a full flag. An overrun flag reports a frame that was lost because the previous word had not been read. Each flag can raise a level interrupt request.

Two clock phases are supported. In normal phase the first bit appears on the first drive edge. In SPI phase the first bit must already be valid before the first edge. Between SPI frames the data line shows bit 0 of the next queued word, or rests HIGH when nothing is queued.

Top module: `csync_slave`

## Requirements
- R1: A `tx_wr` pulse while `tx_en`=1 stores `tx_data` and clears `tx_empty` on the next cycle. A `tx_wr` pulse while `tx_en`=0 is ignored, and `tx_empty` stays 1.
- R2: In normal phase (`spi_phase`=0), `sck_inv`=0 drives data on the falling edge of `sck` and samples on the rising edge, with `sck` idling HIGH. `sck_inv`=1 reverses both edges, with `sck` idling LOW. Bits travel least significant bit first.
- R3: `tx_empty` returns to 1 when the first bit of a frame is put out. In normal phase that is the first drive edge; in SPI phase it is the first sample edge.
- R4: `sdi` is sampled on each sample edge while `rx_en`=1. After the last bit, `rx_full` sets and `rx_data` holds the frame right-aligned, with the first bit received in bit 0. An `rx_rd` pulse clears `rx_full`.
- R5: In SPI phase (`spi_phase`=1), `sck` idles HIGH, bits are sampled on the falling edge and shifted on the rising edge. Outside a frame, `sdo` carries bit 0 of the queued word while `tx_empty`=0 and is HIGH while `tx_empty`=1.
- R6: The frame length is `frame_len` bits. Values below 5 act as 5, and values above 9 act as 9.
- R7: If a frame completes while `rx_full`=1 and no read is made in that cycle, `overrun` sets and `rx_data` keeps the old word. `rx_rd` clears `overrun`. If a read and a completion fall in the same cycle, the new word is stored, `rx_full` stays 1 and no overrun is flagged.
- R8: `tx_irq` is `tx_empty` gated by `tx_ie`. `rx_irq` is `rx_full` gated by `rx_ie`.
- R9: While `rx_en` and `tx_en` are both 0, the bit position returns to the start of a frame. `sdo` is HIGH whenever `out_en`=0 or `tx_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| spi_phase | input | 1 | 1 selects SPI phase |
| sck_inv | input | 1 | Edge swap in normal phase |
| out_en | input | 1 | Enables driving of sdo |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| frame_len | input | 4 | Bits per frame (5 to 9) |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | 9 | Transmit word |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 9 | Received word |
| tx_empty | output | 1 | Transmit register empty |
| rx_full | output | 1 | Receive register full |
| overrun | output | 1 | A received frame was lost |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Two receive events can land in the same cycle: the completion of a frame and a read strobe from software. The bench first fills the receive register. It then starts a second frame and places `rx_rd` exactly on the cycle in which the last synchronized sample edge takes effect, which is three system clocks after it changes `sck`. The outcome is correct only if `rx_full` remains set, `overrun` stays clear and `rx_data` shows the second word. A separate run without the read confirms that the old word is kept and `overrun` rises.

// File: rtl/csync_slave.sv
module csync_slave #(
  parameter int MAXW = 9,
  parameter int MINW = 5,
  parameter int LW   = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck,
  input  logic            sdi,
  output logic            sdo,
  input  logic            spi_phase,
  input  logic            sck_inv,
  input  logic            out_en,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic [LW-1:0]   frame_len,
  input  logic            tx_wr,
  input  logic [MAXW-1:0] tx_data,
  input  logic            rx_rd,
  output logic [MAXW-1:0] rx_data,
  output logic            tx_empty,
  output logic            rx_full,
  output logic            overrun,
  input  logic            tx_ie,
  input  logic            rx_ie,
  output logic            tx_irq,
  output logic            rx_irq
);
  logic s1, s2, sd;
  logic [LW-1:0] bitcnt, len;
  logic [MAXW-1:0] tdr, tsh, rsh, rx_next, rx_word;
  logic tx_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, sd} <= '0;
    else        {s1, s2, sd} <= {sck, s1, s2};

  wire rise   = s2 & ~sd;
  wire fall   = ~s2 & sd;
  wire swap   = spi_phase | sck_inv;
  wire smp_ev = swap ? fall : rise;
  wire drv_ev = swap ? rise : fall;
  wire active = rx_en | tx_en;
  wire tx_on  = tx_en & out_en;

  always_comb
    if (frame_len < LW'(MINW))      len = LW'(MINW);
    else if (frame_len > LW'(MAXW)) len = LW'(MAXW);
    else                            len = frame_len;

  wire last  = active & smp_ev & (bitcnt == len - LW'(1));
  wire load  = tx_on & ~tx_empty & ~tx_act & (bitcnt == '0) & (spi_phase ? smp_ev : drv_ev);
  wire shift = tx_act & drv_ev;

  assign rx_next = {sdi, rsh[MAXW-1:1]};
  assign rx_word = rx_next >> (LW'(MAXW) - len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      tx_act   <= 1'b0;
      tdr      <= '0;
      tsh      <= '0;
      rsh      <= '0;
      rx_data  <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (!active) begin
        bitcnt <= '0;
        tx_act <= 1'b0;
      end else if (smp_ev) begin
        bitcnt <= last ? '0 : bitcnt + LW'(1);
        if (last) tx_act <= 1'b0;
      end
      if (shift) tsh <= tsh >> 1;
      if (load) begin
        tsh      <= tdr;
        tx_act   <= 1'b1;
        tx_empty <= 1'b1;
      end
      if (tx_wr && tx_en) begin
        tdr      <= tx_data;
        tx_empty <= 1'b0;
      end
      if (active && smp_ev && rx_en) rsh <= rx_next;
      if (rx_rd) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (last && rx_en) begin
        if (rx_full && !rx_rd) overrun <= 1'b1;
        else begin
          rx_data <= rx_word;
          rx_full <= 1'b1;
        end
      end
    end
  end

  assign sdo = !tx_on ? 1'b1 :
               tx_act ? tsh[0] :
               (spi_phase && !tx_empty) ? tdr[0] : 1'b1;

  assign tx_irq = tx_ie & tx_empty;
  assign rx_irq = rx_ie & rx_full;
endmodule

// File: rtl/csync_slave_chk.sv
module csync_slave_chk #(
  parameter int MAXW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sdo,
  input logic            tx_en,
  input logic            rx_en,
  input logic            tx_wr,
  input logic [MAXW-1:0] rx_data,
  input logic            tx_empty,
  input logic            rx_full,
  input logic            overrun,
  input logic            tx_irq,
  input logic            rx_irq
);
  p_txe_fall_by_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(tx_wr && tx_en));

  p_rxfull_needs_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_en));

  p_overrun_keeps_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (rx_full && $stable(rx_data)));

  p_sdo_high_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> sdo);

  p_tx_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_empty);

  p_rx_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
endmodule

bind csync_slave csync_slave_chk #(.MAXW(MAXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .tx_en(tx_en), .rx_en(rx_en),
  .tx_wr(tx_wr), .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
  .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/csync_slave_tb_top.sv
module csync_slave_tb_top;
  localparam int H = 6;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sck, sdi, sdo, spi_phase, sck_inv, out_en, tx_en, rx_en;
  logic [3:0] frame_len;
  logic tx_wr, rx_rd, tx_ie, rx_ie;
  logic [8:0] tx_data, rx_data, m;
  logic tx_empty, rx_full, overrun, tx_irq, rx_irq;

  int errs = 0, checks = 0;
  bit auto_rd = 0;
  logic [8:0] expq[$];

  csync_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sdo(sdo),
    .spi_phase(spi_phase), .sck_inv(sck_inv), .out_en(out_en),
    .tx_en(tx_en), .rx_en(rx_en), .frame_len(frame_len),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [8:0] msk(input int n);
    logic [9:0] v;
    v = (10'd1 << n) - 10'd1;
    return v[8:0];
  endfunction

  task automatic wr(input logic [8:0] d);
    tx_data = d; tx_wr = 1'b1; cyc(1); tx_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    rx_rd = 1'b1; cyc(1); rx_rd = 1'b0;
  endtask

  // Master model; rd_last places a read on the completion cycle (SPI only)
  task automatic xfer(input logic [8:0] mosi, input int n, output logic [8:0] miso,
                      input bit push, input bit rd_last);
    miso = '0;
    if (push) expq.push_back(mosi & msk(n));
    for (int i = 0; i < n; i++) begin
      if (spi_phase) begin
        sdi = mosi[i]; cyc(1); miso[i] = sdo;
        sck = ~sck;
        if (rd_last && i == n - 1) begin
          cyc(2); rx_rd = 1'b1; cyc(1); rx_rd = 1'b0; cyc(H - 3);
        end else cyc(H);
        sck = ~sck; cyc(H);
      end else begin
        sck = ~sck; sdi = mosi[i]; cyc(H); miso[i] = sdo;
        sck = ~sck; cyc(H);
      end
    end
    cyc(4);
  endtask

  task automatic set_mode(input bit spi, input bit inv, input logic idle);
    rx_en = 0; tx_en = 0; cyc(2);
    sck = idle; spi_phase = spi; sck_inv = inv; cyc(6);
    rx_en = 1; tx_en = 1; cyc(1);
  endtask

  // Scoreboard monitor: pops the expected word on each new receive
  initial begin
    logic [8:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && auto_rd && rx_full) begin
        if (expq.size() == 0) chk(1'b0, "R4 unexpected word", rx_data, 0);
        else begin
          e = expq.pop_front();
          chk(rx_data == e, "R4 received word", rx_data, e);
        end
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        chk(!rx_full, "R4 read clears full", rx_full, 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 0; sck = 1; sdi = 0; spi_phase = 0; sck_inv = 0; out_en = 0;
    tx_en = 0; rx_en = 0; frame_len = 4'd8; tx_wr = 0; tx_data = '0;
    rx_rd = 0; tx_ie = 0; rx_ie = 0;
    cyc(5); rst_n = 1; cyc(2);

    chk(tx_empty == 1, "R1 reset tx_empty", tx_empty, 1);
    chk(rx_full == 0 && overrun == 0, "R4 reset rx flags", {rx_full, overrun}, 0);
    chk(sdo == 1, "R9 reset sdo", sdo, 1);

    wr(9'h0F0); cyc(1);
    chk(tx_empty == 1, "R1 write ignored with tx off", tx_empty, 1);

    out_en = 1; tx_en = 1; rx_en = 1; auto_rd = 1; cyc(2);
    // normal phase, drive falling / sample rising
    wr(9'h0A5); cyc(1);
    chk(tx_empty == 0, "R1 write clears empty", tx_empty, 0);
    xfer(9'h03C, 8, m, 1, 0);
    chk(m == 9'h0A5, "R2 normal tx word", m, 9'h0A5);
    chk(tx_empty == 1, "R3 empty after frame", tx_empty, 1);

    // normal phase, swapped edges, 5-bit frames
    set_mode(0, 1, 1'b0);
    frame_len = 4'd5;
    wr(9'h013);
    xfer(9'h00B, 5, m, 1, 0);
    chk(m == 9'h013, "R2 swapped edges tx word", m, 9'h013);

    // SPI phase
    set_mode(1, 0, 1'b1);
    frame_len = 4'd8;
    wr(9'h06A); cyc(6);
    chk(sdo == 0, "R5 first bit before edge", sdo, 0);
    chk(tx_empty == 0, "R3 empty held before first edge", tx_empty, 0);
    xfer(9'h0C3, 8, m, 1, 0);
    chk(m == 9'h06A, "R5 spi tx word", m, 9'h06A);
    chk(tx_empty == 1, "R3 empty after spi frame", tx_empty, 1);
    chk(sdo == 1, "R5 idle high when empty", sdo, 1);
    wr(9'h0B5); cyc(6);
    chk(sdo == 1, "R5 queued bit0 shown (1)", sdo, 1);
    xfer(9'h05A, 8, m, 1, 0);
    chk(m == 9'h0B5, "R5 second spi word", m, 9'h0B5);

    // frame length clamping
    frame_len = 4'd12;
    wr(9'h1C3); cyc(6);
    xfer(9'h155, 9, m, 1, 0);
    chk(m == 9'h1C3, "R6 clamp high to 9 bits", m, 9'h1C3);
    frame_len = 4'd2;
    wr(9'h00E); cyc(6);
    chk(sdo == 0, "R5 queued bit0 shown (0)", sdo, 0);
    xfer(9'h019, 5, m, 1, 0);
    chk(m == 9'h00E, "R6 clamp low to 5 bits", m, 9'h00E);
    chk(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);

    // interrupts, overrun and coincident read
    frame_len = 4'd8; auto_rd = 0; tx_ie = 1; rx_ie = 1; cyc(1);
    chk(tx_irq == 1, "R8 tx irq on empty", tx_irq, 1);
    wr(9'h000); cyc(1);
    chk(tx_irq == 0, "R8 tx irq off when queued", tx_irq, 0);
    chk(rx_irq == 0, "R8 rx irq off when not full", rx_irq, 0);
    xfer(9'h055, 8, m, 0, 0);
    chk(rx_full == 1 && rx_data == 9'h055, "R4 full with word", rx_data, 9'h055);
    chk(rx_irq == 1, "R8 rx irq on full", rx_irq, 1);
    xfer(9'h0AA, 8, m, 0, 0);
    chk(overrun == 1, "R7 overrun set", overrun, 1);
    chk(rx_data == 9'h055, "R7 old word kept", rx_data, 9'h055);
    rd_pulse(); cyc(1);
    chk(rx_full == 0 && overrun == 0, "R7 read clears flags", {rx_full, overrun}, 0);
    xfer(9'h021, 8, m, 0, 0);
    xfer(9'h042, 8, m, 0, 1);
    chk(rx_full == 1, "R7 coincident read keeps full", rx_full, 1);
    chk(overrun == 0, "R7 coincident read no overrun", overrun, 0);
    chk(rx_data == 9'h042, "R7 coincident read new word", rx_data, 9'h042);
    rd_pulse(); cyc(1);

    // disable resets the bit position
    auto_rd = 1;
    xfer(9'h00F, 3, m, 0, 0);
    rx_en = 0; tx_en = 0; cyc(4);
    chk(sdo == 1, "R9 sdo high with tx off", sdo, 1);
    rx_en = 1; cyc(2);
    xfer(9'h096, 8, m, 1, 0);
    cyc(4);
    chk(expq.size() == 0, "R9 frame aligned after disable", expq.size(), 0);

    tx_en = 1; cyc(1);
    wr(9'h000); cyc(2);
    out_en = 0; cyc(1);
    chk(sdo == 1, "R9 sdo high with output off", sdo, 1);
    out_en = 1; cyc(1);
    chk(sdo == 0, "R5 queued bit0 after output on", sdo, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule